// File: doc/BRIEF.md
# Two-of-Seven Decimal Digit Encoder and Checker

This block carries decimal digits in a seven-bit weighted code. Each bit stands for a weight, and a digit is the sum of the two weights that are set. Seven bits are used instead of four because a single flipped bit then always produces a word that can be told apart from a good one.

The block has two independent paths. The transmit path takes a BCD digit and produces its seven-bit word. It flags any BCD value above nine as unusable. The receive path takes a seven-bit word, decides whether it is well formed, and if it is, returns the decimal digit. A malformed word raises an error flag. No correction is attempted, because a word with one bit wrong sits one bit away from more than one good word.

With the default setting, both results are captured into output registers on a strobe, so one digit is handled per strobe. With the other setting, the outputs follow the inputs combinationally.

Top module: `bq_codec`

## Requirements
- R1: Bit 6 of the word carries weight 5, bit 5 carries weight 0, and bits 4 down to 0 carry weights 4, 3, 2, 1 and 0. Encoding BCD 0 to 4 sets bit 5 plus the one low bit whose weight equals the digit, giving 0100001, 0100010, 0100100, 0101000 and 0110000.
- R2: Encoding BCD 5 to 9 sets bit 6 plus the low bit of weight (digit minus 5), giving 1000001 through 1010000.
- R3: A BCD input of 10 to 15 produces an all-zero word and raises `bcd_bad`. For BCD 0 to 9, `bcd_bad` is low.
- R4: A received word with exactly one bit set among bits 6..5 and exactly one bit set among bits 4..0 raises `word_ok`. Its `digit_out` is the sum of the two weights.
- R5: A received word whose count of set bits is not two raises `word_err`, for example 0100101 or 0000000.
- R6: A received word with two bits set that both lie in the same group raises `word_err`, for example 1100000 or 0000011.
- R7: Whenever `word_err` is high, `digit_out` is 0.
- R8: In registered mode, the outputs take the new results on the first rising clock edge at which `stb` is high. On edges where `stb` is low, the outputs hold their values.
- R9: While `rst_n` is low at a rising edge, all registered outputs clear to zero.
- R10: `word_ok` and `word_err` are never high together, and after a strobe exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb | input | 1 | Capture strobe for both paths (registered mode) |
| bcd_in | input | 4 | BCD digit to encode |
| code_out | output | 7 | Encoded seven-bit word |
| bcd_bad | output | 1 | BCD input was above nine |
| rx_word | input | 7 | Received seven-bit word to check |
| digit_out | output | 4 | Decoded digit, 0 on error |
| word_ok | output | 1 | Received word is well formed |
| word_err | output | 1 | Received word is malformed |

## Verification
The hardest case to reach from the ports is a word with exactly two bits set where both bits fall in the same group. A check that only counts set bits would accept such a word. The stimulus therefore sweeps all 128 receive words, which covers 1100000 and every same-group pair in the low five bits, and compares each result against a decoder in the bench that searches the ten legal encodings. The hold behaviour is reached by changing both inputs on cycles where the strobe is low, and by sampling just before the capturing edge.

// File: rtl/bq_pkg.sv
// Shared sizes and types for the two-of-seven digit codec.
// Assumes a fixed layout: two "high" bits (weights 5, 0) above five
// "low" bits (weights 4..0), most significant first.
package bq_pkg;
    localparam int BCD_W  = 4;
    localparam int HI_W   = 2;
    localparam int LOW_W  = 5;
    localparam int CODE_W = HI_W + LOW_W;
    localparam int DIGITS = 10;

    typedef logic [BCD_W-1:0]  digit_t;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/bq_encoder.sv
// Converts a BCD digit into the seven-bit two-of-seven word.
// Assumes bcd values above DIGITS-1 are illegal; they give an all-zero
// word and raise bad.
module bq_encoder
    import bq_pkg::*;
(
    input  digit_t bcd,
    output code_t  code,
    output logic   bad
);
    logic   upper;
    digit_t rem;

    // Split the digit into its high-group choice and low-group weight.
    always_comb begin
        bad   = (bcd > digit_t'(DIGITS - 1));
        upper = (bcd >= digit_t'(LOW_W));
        rem   = upper ? bcd - digit_t'(LOW_W) : bcd;
    end

    // One bit in each group; the whole word is blanked for bad input.
    assign code[CODE_W-1] = !bad && upper;
    assign code[CODE_W-2] = !bad && !upper;

    for (genvar i = 0; i < LOW_W; i++) begin : g_low
        assign code[i] = !bad && (rem == digit_t'(i));
    end
endmodule

// File: rtl/bq_checker.sv
// Checks a received two-of-seven word and decodes it to a digit.
// A word is good only with exactly one bit set in each group; the
// digit is forced to zero for any bad word.
module bq_checker
    import bq_pkg::*;
(
    input  code_t  word,
    output digit_t digit,
    output logic   ok,
    output logic   err
);
    logic [HI_W-1:0]  hi;
    logic [LOW_W-1:0] lo;
    logic             hi_one;
    logic             lo_one;
    digit_t           pos;

    assign hi = word[CODE_W-1 -: HI_W];
    assign lo = word[LOW_W-1:0];

    // Exactly-one-set test for each group.
    always_comb begin
        hi_one = (hi != '0) && ((hi & (hi - 1'b1)) == '0);
        lo_one = (lo != '0) && ((lo & (lo - 1'b1)) == '0);
    end

    // Weight of the set low-group bit.
    always_comb begin
        pos = '0;
        for (int i = 0; i < LOW_W; i++) begin
            if (lo[i]) pos = digit_t'(i);
        end
    end

    // Combine validity and the two weights into the result.
    always_comb begin
        ok    = hi_one && lo_one;
        err   = !ok;
        digit = ok ? pos + (hi[HI_W-1] ? digit_t'(LOW_W) : '0) : '0;
    end
endmodule

// File: rtl/bq_codec.sv
// Two-of-seven digit codec: an encode path and a check/decode path.
// REGISTERED=1 captures both results on stb with a synchronous
// active-low reset; REGISTERED=0 drives the outputs combinationally.
module bq_codec
    import bq_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic [BCD_W-1:0]    bcd_in,
    output logic [CODE_W-1:0]   code_out,
    output logic                bcd_bad,
    input  logic [CODE_W-1:0]   rx_word,
    output logic [BCD_W-1:0]    digit_out,
    output logic                word_ok,
    output logic                word_err
);
    code_t  enc_code;
    logic   enc_bad;
    digit_t chk_digit;
    logic   chk_ok;
    logic   chk_err;

    bq_encoder u_enc (
        .bcd  (bcd_in),
        .code (enc_code),
        .bad  (enc_bad)
    );

    bq_checker u_chk (
        .word  (rx_word),
        .digit (chk_digit),
        .ok    (chk_ok),
        .err   (chk_err)
    );

    if (REGISTERED) begin : g_reg
        logic rst_q;

        // Capture both results on strobe; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_out  <= '0;
                bcd_bad   <= 1'b0;
                digit_out <= '0;
                word_ok   <= 1'b0;
                word_err  <= 1'b0;
            end else if (stb) begin
                code_out  <= enc_code;
                bcd_bad   <= enc_bad;
                digit_out <= chk_digit;
                word_ok   <= chk_ok;
                word_err  <= chk_err;
            end
        end

        // Remember that the previous edge was out of reset.
        always_ff @(posedge clk) begin
            rst_q <= rst_n;
        end

        a_r8_hold_without_strobe: assert property (@(posedge clk)
            disable iff (!rst_n)
            (rst_q === 1'b1 && !stb) |=> ($stable(code_out) && $stable(digit_out)
                && $stable(word_ok) && $stable(word_err) && $stable(bcd_bad)));

        a_r9_reset_clears: assert property (@(posedge clk)
            !rst_n |=> (code_out == '0 && digit_out == '0 && !word_ok
                && !word_err && !bcd_bad));

        a_r10_one_flag_after_strobe: assert property (@(posedge clk)
            disable iff (!rst_n)
            stb |=> (word_ok != word_err));
    end else begin : g_comb
        assign code_out  = enc_code;
        assign bcd_bad   = enc_bad;
        assign digit_out = chk_digit;
        assign word_ok   = chk_ok;
        assign word_err  = chk_err;
    end

    a_r10_flags_exclusive: assert property (@(posedge clk)
        disable iff (!rst_n)
        !(word_ok && word_err));

    a_r7_err_gives_zero: assert property (@(posedge clk)
        disable iff (!rst_n)
        word_err |-> (digit_out == '0));

    a_r3_bad_gives_blank: assert property (@(posedge clk)
        disable iff (!rst_n)
        bcd_bad |-> (code_out == '0));

    a_r4_ok_digit_in_range: assert property (@(posedge clk)
        disable iff (!rst_n)
        word_ok |-> (digit_out <= digit_t'(DIGITS - 1)));
endmodule

// File: tb/bq_codec_test.sv
module bq_codec_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       stb;
    logic [3:0] bcd_in;
    logic [6:0] code_out;
    logic       bcd_bad;
    logic [6:0] rx_word;
    logic [3:0] digit_out;
    logic       word_ok;
    logic       word_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state: what the outputs should currently show.
    int m_code, m_bad, m_digit, m_ok, m_err;

    always #5 clk = ~clk;

    bq_codec uut (
        .clk(clk), .rst_n(rst_n), .stb(stb), .bcd_in(bcd_in),
        .code_out(code_out), .bcd_bad(bcd_bad), .rx_word(rx_word),
        .digit_out(digit_out), .word_ok(word_ok), .word_err(word_err)
    );

    function automatic int enc(int d);
        if (d > 9) return 0;
        return ((d >= 5) ? 64 : 32) + (1 << (d % 5));
    endfunction

    function automatic int dec(int w);
        for (int d = 0; d < 10; d++) if (enc(d) == w) return d;
        return -1;
    endfunction

    function automatic int ones(int w);
        int n = 0;
        for (int i = 0; i < 7; i++) n += (w >> i) & 1;
        return n;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all(string rq_enc, string rq_dec, string rq_dig);
        chk(rq_enc, int'(code_out), m_code);
        chk(rq_enc, int'(bcd_bad), m_bad);
        chk(rq_dec, int'(word_ok), m_ok);
        chk(rq_dec, int'(word_err), m_err);
        chk(rq_dig, int'(digit_out), m_digit);
    endtask

    // One clock: drive at negedge, update model at the edge, compare after it.
    task automatic step(bit s, int b, int w);
        string re, rd, rg;
        int d;
        @(negedge clk);
        stb = s; bcd_in = 4'(b); rx_word = 7'(w);
        @(posedge clk);
        if (!rst_n) begin
            m_code = 0; m_bad = 0; m_digit = 0; m_ok = 0; m_err = 0;
        end else if (s) begin
            d = dec(w);
            m_code = enc(b); m_bad = (b > 9);
            m_ok = (d >= 0); m_err = (d < 0);
            m_digit = (d >= 0) ? d : 0;
        end
        #2;
        if (!rst_n)      begin re = "R9"; rd = "R9"; rg = "R9"; end
        else if (!s)     begin re = "R8"; rd = "R8"; rg = "R8"; end
        else begin
            re = (b > 9) ? "R3" : ((b >= 5) ? "R2" : "R1");
            if (dec(w) >= 0)      begin rd = "R4"; rg = "R4"; end
            else if (ones(w) != 2) begin rd = "R5"; rg = "R7"; end
            else                  begin rd = "R6"; rg = "R7"; end
        end
        compare_all(re, rd, rg);
    endtask

    initial begin
        rst_n = 1'b0; stb = 1'b0; bcd_in = '0; rx_word = '0;
        m_code = 0; m_bad = 0; m_digit = 0; m_ok = 0; m_err = 0;
        // R9: reset state
        step(1'b1, 7, 7'b1000100);
        step(1'b0, 0, 0);
        rst_n = 1'b1;

        // R1, R2, R4: every legal digit, encoded and decoded back
        for (int d = 0; d < 10; d++) step(1'b1, d, enc(d));
        // Named points: 0100101 (R5), 1100000 and 0000011 (R6), zero word (R5)
        step(1'b1, 12, 7'b0100101);
        step(1'b1, 3,  7'b1100000);
        step(1'b1, 9,  7'b0000011);
        step(1'b1, 15, 7'b0000000);

        // R8: inputs change while strobe is low; outputs must hold
        step(1'b0, 2, 7'b0100100);
        step(1'b0, 11, 7'b1010000);

        // R8: no update before the capturing edge
        @(negedge clk);
        stb = 1'b1; bcd_in = 4'd5; rx_word = 7'b1000001;
        #4;
        chk("R8", int'(code_out), m_code);
        chk("R8", int'(digit_out), m_digit);
        @(posedge clk);
        m_code = enc(5); m_bad = 0; m_ok = 1; m_err = 0; m_digit = 5;
        #2;
        compare_all("R2", "R4", "R4");

        // R3-R7: exhaustive receive words, BCD cycling through all 16 codes
        for (int w = 0; w < 128; w++) step(1'b1, w % 16, w);

        // R10 after strobe is covered by the comparisons; R9 reset mid-run
        rst_n = 1'b0;
        step(1'b1, 4, 7'b0110000);
        rst_n = 1'b1;
        step(1'b0, 4, 7'b0110000);
        step(1'b1, 8, 7'b1001000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule